// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small system between three power modes: full-run, CPU-only sleep and deep sleep. In deep sleep the fast clock is stopped and the core logic and SRAM are held in retention, while the slow clock keeps running. The CPU asks for a mode with a one-cycle request. Any wake event brings the system back to full-run. The block drives enables for the CPU clock gate, the high-frequency clock, the low-frequency clock and the fast peripheral domain. It also drives a retention request that is answered by an acknowledge from the retention cells.

Deep-sleep entry happens in a fixed order. The block raises retention, waits for the acknowledge, and only then stops the fast clock. Exit runs the other way. The fast clock comes back first and is given a programmable number of low-frequency ticks to settle. Retention is then released, and the CPU is ungated once the acknowledge has dropped. A wake that arrives while retention is still being set up cancels the entry. The committed mode is reported on a status output.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in full-run. `cpu_clk_en`, `hf_clk_en`, `lf_clk_en` and `periph_en` are 1, `ret_req` is 0, and `mode_status` is 0.
- R2: In full-run, a request with `req_mode`=1 and no wake moves the block to sleep on the next cycle. In sleep only `cpu_clk_en` is 0; the fast clock and peripherals stay enabled and `ret_req` stays 0.
- R3: In full-run, a request with `req_mode`=2 and no wake raises `ret_req` and clears `cpu_clk_en` on the next cycle, while `hf_clk_en` stays 1. On the cycle after `ret_ack` is sampled high, `hf_clk_en` and `periph_en` drop to 0.
- R4: A wake sampled while the block waits for `ret_ack` cancels the entry. On the next cycle all full-run outputs return and `ret_req` is 0.
- R5: A wake sampled in sleep returns the block to full-run on the next cycle.
- R6: A wake sampled in deep sleep sets `hf_clk_en` to 1 on the next cycle, with `ret_req` still 1. After `settle_lf` low-frequency ticks have been counted, `ret_req` falls on the following cycle. `cpu_clk_en` returns on the cycle after `ret_ack` is sampled low.
- R7: `mode_status` holds 0 for full-run, 1 for sleep and 2 for deep sleep. It changes one cycle after the block enters that mode and holds its value through entry and exit sequences.
- R8: `lf_clk_en` is 1 in every mode and every step of every sequence.
- R9: Requests with `req_mode` 0 or 3 are ignored. Any request made while not in full-run is ignored.
- R10: In full-run, a wake in the same cycle as a request takes priority, and the block stays in full-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode: 1 sleep, 2 deep sleep |
| wake | input | 1 | Wake event |
| ret_ack | input | 1 | Retention acknowledge |
| lf_tick | input | 1 | Low-frequency tick (a strobe, or a level when `LF_IS_LEVEL`=1) |
| settle_lf | input | CNT_W | Fast-clock settle time, in low-frequency ticks |
| cpu_clk_en | output | 1 | CPU clock-gate enable |
| hf_clk_en | output | 1 | High-frequency clock enable |
| lf_clk_en | output | 1 | Low-frequency clock enable |
| ret_req | output | 1 | SRAM and fast-logic retention request |
| periph_en | output | 1 | Fast peripheral domain enable |
| mode_status | output | 2 | Committed mode |

## Verification
The hardest situations to reach are a wake that lands during the wait for the retention acknowledge, and the exit path with a settle count and an acknowledge that is still high. Directed sequences walk the complete deep-sleep round trip with a fixed settle count and then cancel an entry. A long seeded random phase then toggles wake, acknowledge, ticks and settle values independently, so cancels, zero-length settles and late acknowledge drops occur many times. A lockstep bench model is compared every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_NAP   = 3'd1,
      ST_ENTER = 3'd2,
      ST_DEEP  = 3'd3,
      ST_SETTL = 3'd4,
      ST_RELS  = 3'd5
   } lpm_state_e;

   localparam logic [1:0] MODE_RUN  = 2'd0;
   localparam logic [1:0] MODE_NAP  = 2'd1;
   localparam logic [1:0] MODE_DEEP = 2'd2;
endpackage

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
   parameter int CNT_W       = 8,
   parameter bit LF_IS_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             lf_in,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("lpm_settle_timer: CNT_W must be at least 1");
      end
      if (LF_IS_LEVEL) begin : g_edge
         logic lf_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lf_q <= 1'b0;
            else        lf_q <= lf_in;
         end
         assign tick = lf_in & ~lf_q;
      end else begin : g_strobe
         assign tick = lf_in;
      end
   endgenerate

   assign done = run && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run)             cnt_q <= '0;
      else if (!done && tick)    cnt_q <= cnt_q + 1'b1;
   end

   a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run && !done |=> cnt_q <= limit || !$stable(limit));
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic       wake,
   input  logic       ret_ack,
   input  logic       settle_done,
   output lpm_state_e state,
   output logic [1:0] status
);
   lpm_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN: if (!wake && req_valid) begin
            if (req_mode == MODE_NAP)       nxt = ST_NAP;
            else if (req_mode == MODE_DEEP) nxt = ST_ENTER;
         end
         ST_NAP:   if (wake) nxt = ST_RUN;
         ST_ENTER: if (wake) nxt = ST_RUN;
                   else if (ret_ack) nxt = ST_DEEP;
         ST_DEEP:  if (wake) nxt = ST_SETTL;
         ST_SETTL: if (settle_done) nxt = ST_RELS;
         ST_RELS:  if (!ret_ack) nxt = ST_RUN;
         default:  nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         status <= MODE_RUN;
      end else begin
         state <= nxt;
         unique case (state)
            ST_RUN:  status <= MODE_RUN;
            ST_NAP:  status <= MODE_NAP;
            ST_DEEP: status <= MODE_DEEP;
            default: status <= status;
         endcase
      end
   end

   a_r5_nap_wake: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_NAP && wake |=> state == ST_RUN);
   a_r4_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ENTER && wake |=> state == ST_RUN);
   a_r10_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RUN && wake |=> state == ST_RUN);
   a_r7_status_deep: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DEEP |=> status == MODE_DEEP);
endmodule

// File: rtl/lpm_dom_decode.sv
module lpm_dom_decode
   import lpm_pkg::*;
(
   input  lpm_state_e state,
   output logic       cpu_en,
   output logic       hf_en,
   output logic       lf_en,
   output logic       ret,
   output logic       per_en
);
   always_comb begin
      lf_en  = 1'b1;
      cpu_en = (state == ST_RUN);
      hf_en  = (state != ST_DEEP);
      ret    = (state == ST_ENTER) || (state == ST_DEEP) || (state == ST_SETTL);
      per_en = (state != ST_DEEP) && (state != ST_SETTL);
   end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter bit LF_IS_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_mode,
   input  logic             wake,
   input  logic             ret_ack,
   input  logic             lf_tick,
   input  logic [CNT_W-1:0] settle_lf,
   output logic             cpu_clk_en,
   output logic             hf_clk_en,
   output logic             lf_clk_en,
   output logic             ret_req,
   output logic             periph_en,
   output logic [1:0]       mode_status
);
   lpm_state_e state;
   logic       settle_done;

   lpm_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .wake(wake), .ret_ack(ret_ack), .settle_done(settle_done),
      .state(state), .status(mode_status)
   );

   lpm_settle_timer #(.CNT_W(CNT_W), .LF_IS_LEVEL(LF_IS_LEVEL)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(state == ST_SETTL), .lf_in(lf_tick),
      .limit(settle_lf), .done(settle_done)
   );

   lpm_dom_decode u_dec (
      .state(state), .cpu_en(cpu_clk_en), .hf_en(hf_clk_en),
      .lf_en(lf_clk_en), .ret(ret_req), .per_en(periph_en)
   );

   a_r3_hf_gated_in_retention: assert property (@(posedge clk) disable iff (!rst_n)
      !hf_clk_en |-> ret_req && !cpu_clk_en);
   a_r3_gate_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hf_clk_en) |-> $past(ret_ack) && $past(ret_req));
   a_r6_release_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ret_req) && hf_clk_en && !periph_en |-> 1'b0);
   a_r6_cpu_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> !ret_req && hf_clk_en);
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int CW    = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, wake = 0, ret_ack = 0, lf_tick = 0;
   logic [1:0] req_mode = 0;
   logic [CW-1:0] settle_lf = 0;
   logic cpu_clk_en, hf_clk_en, lf_clk_en, ret_req, periph_en;
   logic [1:0] mode_status;

   int checks = 0, errors = 0;
   int m_st = 0, m_cnt = 0, m_stat = 0;

   always #(CLK_P/2) clk = ~clk;

   lpm_ctrl #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .wake(wake), .ret_ack(ret_ack), .lf_tick(lf_tick), .settle_lf(settle_lf),
      .cpu_clk_en(cpu_clk_en), .hf_clk_en(hf_clk_en), .lf_clk_en(lf_clk_en),
      .ret_req(ret_req), .periph_en(periph_en), .mode_status(mode_status));

   // {cpu, hf, lf, ret, per} per model state
   function automatic logic [4:0] exp_outs(int st);
      case (st)
         0: return 5'b11101;
         1: return 5'b01101;
         2: return 5'b01111;
         3: return 5'b00110;
         4: return 5'b01110;
         default: return 5'b01101;
      endcase
   endfunction

   function automatic string st_tag(int st);
      case (st)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [4:0] dut_outs();
      return {cpu_clk_en, hf_clk_en, lf_clk_en, ret_req, periph_en};
   endfunction

   task automatic compare_all();
      chk(dut_outs() == exp_outs(m_st), st_tag(m_st), dut_outs(), exp_outs(m_st));
      chk(mode_status == m_stat[1:0], "R7", mode_status, m_stat);
      chk(lf_clk_en == 1'b1, "R8", lf_clk_en, 1);
   endtask

   task automatic step();
      int ns, nc, nstat;
      @(posedge clk);
      ns = m_st; nc = m_cnt; nstat = m_stat;
      case (m_st)
         0: if (!wake && req_valid && req_mode == 2'd1) ns = 1;
            else if (!wake && req_valid && req_mode == 2'd2) ns = 2;
         1: if (wake) ns = 0;
         2: if (wake) ns = 0; else if (ret_ack) ns = 3;
         3: if (wake) ns = 4;
         4: if (m_cnt >= int'(settle_lf)) ns = 5;
         5: if (!ret_ack) ns = 0;
         default: ns = 0;
      endcase
      if (m_st != 4) nc = 0;
      else if (m_cnt < int'(settle_lf) && lf_tick) nc = m_cnt + 1;
      if (m_st == 0) nstat = 0;
      else if (m_st == 1) nstat = 1;
      else if (m_st == 3) nstat = 2;
      m_st = ns; m_cnt = nc; m_stat = nstat;
      @(negedge clk);
      compare_all();
      req_valid = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      #(CLK_P * 2 + 1);
      // R1: reset state
      chk(dut_outs() == 5'b11101, "R1", dut_outs(), 5'b11101);
      chk(mode_status == 2'd0, "R1", mode_status, 0);
      @(negedge clk); rst_n = 1;
      step();

      // R10: wake beats a simultaneous sleep request
      wake = 1; req_valid = 1; req_mode = 2'd1; step(); wake = 0;
      chk(cpu_clk_en == 1, "R10", cpu_clk_en, 1);

      // R9: codes 0 and 3 are ignored
      req_valid = 1; req_mode = 2'd0; step();
      req_valid = 1; req_mode = 2'd3; step();
      chk(cpu_clk_en == 1 && !ret_req, "R9", dut_outs(), 5'b11101);

      // R2: sleep
      req_valid = 1; req_mode = 2'd1; step();
      chk(dut_outs() == 5'b01101, "R2", dut_outs(), 5'b01101);
      step();
      chk(mode_status == 2'd1, "R7", mode_status, 1);
      // R9: deep request in sleep ignored
      req_valid = 1; req_mode = 2'd2; step();
      chk(ret_req == 0 && hf_clk_en == 1, "R9", dut_outs(), 5'b01101);
      // R5: wake from sleep
      wake = 1; step(); wake = 0;
      chk(cpu_clk_en == 1, "R5", cpu_clk_en, 1);

      // R3: deep entry with late ack
      settle_lf = 2;
      req_valid = 1; req_mode = 2'd2; step();
      chk(ret_req == 1 && hf_clk_en == 1 && cpu_clk_en == 0, "R3", dut_outs(), 5'b01111);
      step();
      chk(hf_clk_en == 1, "R3", hf_clk_en, 1);
      ret_ack = 1; step();
      chk(hf_clk_en == 0 && periph_en == 0, "R3", dut_outs(), 5'b00110);
      step();
      chk(mode_status == 2'd2, "R7", mode_status, 2);

      // R6: exit with two-tick settle
      wake = 1; step(); wake = 0;
      chk(hf_clk_en == 1 && ret_req == 1 && cpu_clk_en == 0, "R6", dut_outs(), 5'b01110);
      lf_tick = 1; step(); step(); lf_tick = 0;
      chk(ret_req == 1, "R6", ret_req, 1);
      step();
      chk(ret_req == 0 && cpu_clk_en == 0, "R6", dut_outs(), 5'b01101);
      step();
      chk(cpu_clk_en == 0, "R6", cpu_clk_en, 0);
      ret_ack = 0; step();
      chk(cpu_clk_en == 1, "R6", cpu_clk_en, 1);
      chk(mode_status == 2'd2, "R7", mode_status, 2);
      step();
      chk(mode_status == 2'd0, "R7", mode_status, 0);

      // R4: cancel during retention setup
      req_valid = 1; req_mode = 2'd2; step();
      wake = 1; step(); wake = 0;
      chk(dut_outs() == 5'b11101, "R4", dut_outs(), 5'b11101);
      chk(mode_status == 2'd0, "R4", mode_status, 0);

      // random phase
      for (int i = 0; i < 20000; i++) begin
         wake      = ($urandom % 10) == 0;
         req_valid = ($urandom % 3) == 0;
         req_mode  = 2'($urandom % 4);
         ret_ack   = ($urandom % 2) == 1;
         lf_tick   = ($urandom % 5) < 2;
         if (($urandom % 50) == 0) settle_lf = CW'($urandom % 5);
         step();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule